// File: doc/BRIEF.md
# Buffered configuration port controller

This peripheral sits on a 32-bit register bus and moves blocks of words between a local one-frame word buffer and an external 32-bit configuration port. Software loads the buffer through the low part of the address space. It then sets a byte count and a starting word position, and writes the direction register. That single write starts the transfer. In configure mode the engine sends buffer words out on the port. In readback mode it stores words captured from the port into the buffer. While the engine runs, the done flag in the status register is 0. It returns to 1 when the transfer completes or is aborted.

The status register also carries four live flags from the port and a block of bits that are always 1. Any bus write to the status register stops the engine at once. The address map is parameterised: the buffer holds `BUF_WORDS` words, and the registers start at byte address `4*BUF_WORDS`, which is 0x800 at the default depth.

Top module: `cfg_port_ctrl`

## Requirements
- R1: A bus write to a byte address below 0x800 stores the data in buffer word `addr >> 2`. A bus read of that address returns the word on `bus_rdata_o` one clock after the read strobe.
- R2: The byte-count register is at 0x800 and the start-word register is at 0x804. Both are read/write and both read 0 after reset. After reset the status register reads 0x3F when the port flags are idle (error 0, alignment 0, readback-busy 0, abort-low 1).
- R3: Status register layout: bit 0 is done (1 = idle). Bits 4 to 1 always read 1. Bit 8 mirrors `port_cfg_err_i`, bit 7 `port_align_i`, bit 6 `port_rb_busy_i` and bit 5 `port_abort_ni`. All other bits read 0.
- R4: Writing a value with bit 0 = 0 to 0x808 while idle starts a configure transfer. Buffer words are sent in ascending order from the start word, one word per cycle in which `port_wvalid_o` and `port_wready_i` are both high.
- R5: Writing a value with bit 0 = 1 to 0x808 while idle starts a readback. Each cycle in which `port_rvalid_i` and `port_rready_o` are both high stores `port_rdata_i` into the next buffer word, beginning at the start word.
- R6: The number of words moved is the byte count shifted right by 2, limited so that no word past buffer word 511 is used. Buffer words outside the transfer are left unchanged.
- R7: A transfer of zero words drops done for exactly one cycle and makes no port handshake.
- R8: A write to 0x808 while done is 0 has no effect. The running transfer continues unchanged.
- R9: Any bus write to 0x80C aborts the engine, and done reads 1 on the next cycle. A readback word offered in the same cycle as the abort is not stored.
- R10: Bus writes to the buffer are ignored while a transfer is in progress.
- R11: `port_wvalid_o` and `port_rready_o` are never high together, and both are low while idle. Without an abort, `port_wvalid_o` stays high with `port_wdata_o` unchanged until `port_wready_i` accepts the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Bus write strobe |
| bus_re_i | input | 1 | Bus read strobe |
| bus_addr_i | input | ADDR_W | Bus byte address |
| bus_wdata_i | input | DATA_W | Bus write data |
| bus_rdata_o | output | DATA_W | Bus read data, one cycle after the strobe |
| port_wvalid_o | output | 1 | Configure word valid |
| port_wready_i | input | 1 | Configure word accepted |
| port_wdata_o | output | DATA_W | Configure word |
| port_rvalid_i | input | 1 | Readback word valid |
| port_rready_o | output | 1 | Engine ready to take a readback word |
| port_rdata_i | input | DATA_W | Readback word |
| port_cfg_err_i | input | 1 | Port configuration error flag |
| port_align_i | input | 1 | Port alignment flag |
| port_rb_busy_i | input | 1 | Port readback-in-progress flag |
| port_abort_ni | input | 1 | Port abort flag, active low |

## Verification
An abort write to the status register can land in the same clock as a readback handshake. In that case the port sees the word accepted, but the buffer must not take it. The bench provokes this during a readback by holding `port_rvalid_i` off, then raising it on the same falling edge that places the abort write on the bus. It then judges the result at the bus: the target buffer word must still hold the value written before the transfer, and done must read 1. A second case places a direction write and a buffer write inside a stalled configure transfer. The words that come out of the port must show that neither write had any effect.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam int unsigned OFS_SIZE = 0;
  localparam int unsigned OFS_OFF  = 4;
  localparam int unsigned OFS_DIR  = 8;
  localparam int unsigned OFS_STAT = 12;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CFG  = 2'd1,
    ST_RDB  = 2'd2
  } eng_st_e;
endpackage

// File: rtl/cfgp_buf.sv
module cfgp_buf #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned BUF_WORDS = 512,
  localparam int unsigned AW       = $clog2(BUF_WORDS)
) (
  input  logic              clk_i,
  input  logic              a_we_i,
  input  logic              a_re_i,
  input  logic [AW-1:0]     a_addr_i,
  input  logic [DATA_W-1:0] a_wdata_i,
  output logic [DATA_W-1:0] a_rdata_o,
  input  logic              e_we_i,
  input  logic [AW-1:0]     e_addr_i,
  input  logic [DATA_W-1:0] e_wdata_i,
  output logic [DATA_W-1:0] e_rdata_o
);
  logic [DATA_W-1:0] mem_q [BUF_WORDS];

  // engine port wins; bus writes are gated off while busy anyway
  always_ff @(posedge clk_i) begin
    if (e_we_i)      mem_q[e_addr_i] <= e_wdata_i;
    else if (a_we_i) mem_q[a_addr_i] <= a_wdata_i;
    if (a_re_i)      a_rdata_o <= mem_q[a_addr_i];
  end

  assign e_rdata_o = mem_q[e_addr_i];
endmodule

// File: rtl/cfgp_regs.sv
module cfgp_regs
  import cfgp_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned BUF_WORDS = 512,
  localparam int unsigned AW       = $clog2(BUF_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] stat_i,
  input  logic              idle_i,
  output logic              buf_we_o,
  output logic              buf_re_o,
  output logic [AW-1:0]     buf_addr_o,
  output logic              start_o,
  output logic              mode_o,
  output logic              abort_o,
  output logic [DATA_W-1:0] size_o,
  output logic [DATA_W-1:0] off_o,
  output logic              rsel_buf_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned REG_BASE = BUF_WORDS * 4;
  localparam logic [ADDR_W-1:0] A_SIZE = ADDR_W'(REG_BASE + OFS_SIZE);
  localparam logic [ADDR_W-1:0] A_OFF  = ADDR_W'(REG_BASE + OFS_OFF);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(REG_BASE + OFS_DIR);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(REG_BASE + OFS_STAT);

  logic in_buf;
  assign in_buf     = addr_i < A_SIZE;
  assign buf_addr_o = addr_i[AW+1:2];
  assign buf_we_o   = we_i && in_buf && idle_i;
  assign buf_re_o   = re_i && in_buf;
  assign start_o    = we_i && (addr_i == A_DIR);
  assign mode_o     = wdata_i[0];
  assign abort_o    = we_i && (addr_i == A_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      size_o     <= '0;
      off_o      <= '0;
      rsel_buf_o <= 1'b0;
      rdata_o    <= '0;
    end else begin
      if (we_i && addr_i == A_SIZE) size_o <= wdata_i;
      if (we_i && addr_i == A_OFF)  off_o  <= wdata_i;
      if (re_i) begin
        rsel_buf_o <= in_buf;
        unique case (addr_i)
          A_SIZE:  rdata_o <= size_o;
          A_OFF:   rdata_o <= off_o;
          A_STAT:  rdata_o <= stat_i;
          default: rdata_o <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfgp_engine.sv
module cfgp_engine
  import cfgp_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned BUF_WORDS = 512,
  localparam int unsigned AW       = $clog2(BUF_WORDS),
  localparam int unsigned CNT_W    = $clog2(BUF_WORDS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              mode_i,
  input  logic              abort_i,
  input  logic [DATA_W-1:0] size_i,
  input  logic [DATA_W-1:0] off_i,
  output logic              done_o,
  output logic [AW-1:0]     ptr_o,
  output logic              mem_we_o,
  output logic              port_wvalid_o,
  input  logic              port_wready_i,
  input  logic              port_rvalid_i,
  output logic              port_rready_o
);
  eng_st_e           st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] words, room, eff;
  logic              act, hs;

  always_comb begin
    words = size_i >> 2;
    room  = (off_i >= DATA_W'(BUF_WORDS)) ? '0 : DATA_W'(BUF_WORDS) - off_i;
    eff   = (words < room) ? words : room;
  end

  assign act           = cnt_q != '0;
  assign port_wvalid_o = (st_q == ST_CFG) && act;
  assign port_rready_o = (st_q == ST_RDB) && act;
  assign hs            = (port_wvalid_o && port_wready_i) || (port_rready_o && port_rvalid_i);
  assign mem_we_o      = port_rready_o && port_rvalid_i && !abort_i;
  assign done_o        = st_q == ST_IDLE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      ptr_o <= '0;
    end else if (abort_i) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else if (st_q == ST_IDLE) begin
      if (start_i) begin
        st_q  <= mode_i ? ST_RDB : ST_CFG;
        cnt_q <= CNT_W'(eff);
        ptr_o <= off_i[AW-1:0];
      end
    end else if (!act) begin
      st_q <= ST_IDLE;
    end else if (hs) begin
      cnt_q <= cnt_q - 1'b1;
      ptr_o <= ptr_o + 1'b1;
    end
  end
endmodule

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned BUF_WORDS = 512
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic              bus_re_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              port_wvalid_o,
  input  logic              port_wready_i,
  output logic [DATA_W-1:0] port_wdata_o,
  input  logic              port_rvalid_i,
  output logic              port_rready_o,
  input  logic [DATA_W-1:0] port_rdata_i,
  input  logic              port_cfg_err_i,
  input  logic              port_align_i,
  input  logic              port_rb_busy_i,
  input  logic              port_abort_ni
);
  localparam int unsigned AW = $clog2(BUF_WORDS);

  logic              done, start, mode, abort, mem_we, buf_we, buf_re, rsel_buf;
  logic [AW-1:0]     buf_addr, ptr;
  logic [DATA_W-1:0] size_q, off_q, reg_rdata, buf_rdata, stat;

  assign stat = {{(DATA_W-9){1'b0}}, port_cfg_err_i, port_align_i, port_rb_busy_i,
                 port_abort_ni, 4'hF, done};

  cfgp_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUF_WORDS(BUF_WORDS)) u_regs (
    .clk_i, .rst_ni,
    .we_i(bus_we_i), .re_i(bus_re_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .stat_i(stat), .idle_i(done),
    .buf_we_o(buf_we), .buf_re_o(buf_re), .buf_addr_o(buf_addr),
    .start_o(start), .mode_o(mode), .abort_o(abort),
    .size_o(size_q), .off_o(off_q), .rsel_buf_o(rsel_buf), .rdata_o(reg_rdata)
  );

  cfgp_engine #(.DATA_W(DATA_W), .BUF_WORDS(BUF_WORDS)) u_eng (
    .clk_i, .rst_ni,
    .start_i(start), .mode_i(mode), .abort_i(abort),
    .size_i(size_q), .off_i(off_q),
    .done_o(done), .ptr_o(ptr), .mem_we_o(mem_we),
    .port_wvalid_o, .port_wready_i, .port_rvalid_i, .port_rready_o
  );

  cfgp_buf #(.DATA_W(DATA_W), .BUF_WORDS(BUF_WORDS)) u_buf (
    .clk_i,
    .a_we_i(buf_we), .a_re_i(buf_re), .a_addr_i(buf_addr), .a_wdata_i(bus_wdata_i),
    .a_rdata_o(buf_rdata),
    .e_we_i(mem_we), .e_addr_i(ptr), .e_wdata_i(port_rdata_i), .e_rdata_o(port_wdata_o)
  );

  assign bus_rdata_o = rsel_buf ? buf_rdata : reg_rdata;
endmodule

// File: rtl/cfgp_chk.sv
module cfgp_chk #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned BUF_WORDS = 512
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              port_wvalid_o,
  input logic              port_wready_i,
  input logic [DATA_W-1:0] port_wdata_o,
  input logic              port_rready_o,
  input logic              done,
  input logic [DATA_W-1:0] size_q
);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(BUF_WORDS * 4 + 8);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(BUF_WORDS * 4 + 12);

  logic abort_w, start_w;
  assign abort_w = bus_we_i && bus_addr_i == A_STAT;
  assign start_w = bus_we_i && bus_addr_i == A_DIR;

  assert_dir_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(port_wvalid_o && port_rready_o));

  assert_idle_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |-> !port_wvalid_o && !port_rready_o);

  assert_hold_word_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_wvalid_o && !port_wready_i && !abort_w) |=> port_wvalid_o && $stable(port_wdata_o));

  assert_abort_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_w |=> done);

  assert_zero_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_w && done && (size_q >> 2) == '0) |=> !done ##1 done);

  assert_busy_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_w && !done && port_wvalid_o && !port_wready_i) |=> port_wvalid_o);
endmodule

bind cfg_port_ctrl cfgp_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUF_WORDS(BUF_WORDS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
  .port_wvalid_o(port_wvalid_o), .port_wready_i(port_wready_i), .port_wdata_o(port_wdata_o),
  .port_rready_o(port_rready_o), .done(done), .size_q(size_q)
);

// File: tb/cfg_port_ctrl_tb.sv
module cfg_port_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] A_SIZE = 12'h800, A_OFF = 12'h804, A_DIR = 12'h808, A_STAT = 12'h80C;

  typedef struct packed {
    logic        rdb;
    logic [31:0] size;
    logic [31:0] off;
    logic        stall;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'd16, 32'd0,   1'b0},
    '{1'b0, 32'd40, 32'd37,  1'b1},
    '{1'b1, 32'd24, 32'd200, 1'b0},
    '{1'b1, 32'd32, 32'd300, 1'b1},
    '{1'b0, 32'd64, 32'd504, 1'b0},
    '{1'b1, 32'd30, 32'd509, 1'b1}
  };

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        bus_we_i = 1'b0, bus_re_i = 1'b0;
  logic [11:0] bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0, bus_rdata_o;
  logic        port_wvalid_o, port_wready_i, port_rvalid_i, port_rready_o;
  logic [31:0] port_wdata_o, port_rdata_i;
  logic        port_cfg_err_i = 1'b0, port_align_i = 1'b0, port_rb_busy_i = 1'b0, port_abort_ni = 1'b1;

  logic        stub_en = 1'b0, stub_stall = 1'b0, tick = 1'b0, stub_rdy = 1'b0, stub_rv = 1'b0, force_rv = 1'b0;
  logic [31:0] stub_data = '0;
  int          hs_cnt = 0;
  logic [31:0] got [512];
  int          checks = 0, errors = 0;

  assign port_wready_i = stub_rdy;
  assign port_rvalid_i = stub_rv || force_rv;
  assign port_rdata_i  = stub_data;

  cfg_port_ctrl u_dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [31:0] src_word(int i);
    return 32'h5A00_0000 + 32'(i) * 32'h1011;
  endfunction

  function automatic logic [31:0] pat(int v, int i);
    return {8'(v), 8'h3C, 16'(i)};
  endfunction

  // port stub: drive for the coming edge, then note the handshake
  always @(negedge clk_i) begin
    tick      = ~tick;
    stub_rdy  = stub_en && (!stub_stall || tick);
    stub_rv   = stub_en && (!stub_stall || tick);
    stub_data = src_word(hs_cnt);
    #1;
    if (port_wvalid_o && port_wready_i && hs_cnt < 512) begin
      got[hs_cnt] = port_wdata_o;
      hs_cnt++;
    end else if (port_rready_o && port_rvalid_i) hs_cnt++;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk_i);
    bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_we_i = 1'b0;
  endtask

  task automatic bus_read(logic [11:0] a, output logic [31:0] d);
    @(negedge clk_i);
    bus_re_i = 1'b1; bus_addr_i = a;
    @(negedge clk_i);
    bus_re_i = 1'b0;
    d = bus_rdata_o;
  endtask

  task automatic wait_done();
    logic [31:0] s;
    for (int k = 0; k < 3000; k++) begin
      bus_read(A_STAT, s);
      if (s[0]) break;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int n, room, bad;
    #(CLK_PERIOD * 3);
    rst_ni = 1'b1;

    // reset state (R2, R3, R11)
    bus_read(A_SIZE, r); chk("R2 size reset", r, 32'h0);
    bus_read(A_OFF, r);  chk("R2 offset reset", r, 32'h0);
    bus_read(A_STAT, r); chk("R2 status reset", r, 32'h3F);
    chk("R11 idle outputs", {30'b0, port_wvalid_o, port_rready_o}, 32'h0);

    bus_write(A_SIZE, 32'h1234); bus_read(A_SIZE, r); chk("R2 size rw", r, 32'h1234);
    bus_write(A_OFF, 32'h55);    bus_read(A_OFF, r);  chk("R2 offset rw", r, 32'h55);

    port_cfg_err_i = 1'b1; port_rb_busy_i = 1'b1; port_abort_ni = 1'b0;
    bus_read(A_STAT, r); chk("R3 status mirror", r, 32'h15F);
    port_cfg_err_i = 1'b0; port_rb_busy_i = 1'b0; port_abort_ni = 1'b1;
    port_align_i = 1'b1;
    bus_read(A_STAT, r); chk("R3 align bit", r, 32'hBF);
    port_align_i = 1'b0;

    bus_write(12'h010, 32'hCAFE_F00D);
    bus_read(12'h010, r); chk("R1 buffer rw", r, 32'hCAFE_F00D);

    // vector table (R4, R5, R6)
    for (int v = 0; v < NV; v++) begin
      room = 512 - int'(VECS[v].off);
      n = int'(VECS[v].size >> 2);
      if (n > room) n = room;
      for (int i = 0; i <= n; i++)
        if (int'(VECS[v].off) + i < 512)
          bus_write(12'(4 * (int'(VECS[v].off) + i)), VECS[v].rdb ? (32'hDEAD_0000 | 32'(i)) : pat(v, i));
      bus_write(A_SIZE, VECS[v].size);
      bus_write(A_OFF, VECS[v].off);
      @(negedge clk_i);
      hs_cnt = 0; stub_stall = VECS[v].stall; stub_en = 1'b1;
      bus_write(A_DIR, {31'b0, VECS[v].rdb});
      wait_done();
      stub_en = 1'b0;
      chk(VECS[v].rdb ? "R5 R6 readback word count" : "R4 R6 configure word count", 32'(hs_cnt), 32'(n));
      bad = 0;
      for (int i = 0; i < n; i++) begin
        if (VECS[v].rdb) begin
          bus_read(12'(4 * (int'(VECS[v].off) + i)), r);
          if (r !== src_word(i)) bad++;
        end else if (got[i] !== pat(v, i)) bad++;
      end
      chk(VECS[v].rdb ? "R5 readback data" : "R4 configure data", 32'(bad), 32'h0);
      if (VECS[v].rdb && int'(VECS[v].off) + n < 512) begin
        bus_read(12'(4 * (int'(VECS[v].off) + n)), r);
        chk("R6 word past transfer", r, 32'hDEAD_0000 | 32'(n));
      end
    end

    // zero-size transfer (R7)
    bus_write(A_SIZE, 32'd3); bus_write(A_OFF, 32'd0);
    @(negedge clk_i); hs_cnt = 0; stub_stall = 1'b0; stub_en = 1'b1;
    bus_write(A_DIR, 32'd0);
    repeat (4) @(negedge clk_i);
    chk("R7 no handshake", 32'(hs_cnt), 32'h0);
    bus_read(A_STAT, r); chk("R7 done again", {31'b0, r[0]}, 32'h1);
    stub_en = 1'b0;

    // busy: start and buffer writes ignored (R8, R10)
    for (int i = 0; i < 4; i++) bus_write(12'(4 * i), pat(9, i));
    bus_write(A_SIZE, 32'd16);
    @(negedge clk_i); hs_cnt = 0;
    bus_write(A_DIR, 32'd0);
    bus_write(12'h008, 32'h0000_0BAD);
    bus_write(A_DIR, 32'd1);
    bus_read(A_STAT, r); chk("R8 still busy", {31'b0, r[0]}, 32'h0);
    chk("R8 direction unchanged", {30'b0, port_wvalid_o, port_rready_o}, 32'h2);
    stub_en = 1'b1;
    wait_done();
    stub_en = 1'b0;
    chk("R8 words sent", 32'(hs_cnt), 32'd4);
    chk("R10 word kept", got[2], pat(9, 2));
    bus_read(12'h008, r); chk("R10 buffer unchanged", r, pat(9, 2));

    // abort mid configure (R9)
    bus_write(A_DIR, 32'd0);
    bus_write(A_STAT, 32'hFEFE);
    bus_read(A_STAT, r); chk("R9 abort done", r, 32'h3F);
    chk("R9 valid dropped", {31'b0, port_wvalid_o}, 32'h0);

    // abort in the same cycle as a readback handshake (R9)
    bus_write(12'(4 * 100), 32'h1111_2222);
    bus_write(A_SIZE, 32'd8); bus_write(A_OFF, 32'd100);
    bus_write(A_DIR, 32'd1);
    @(negedge clk_i);
    force_rv = 1'b1; bus_we_i = 1'b1; bus_addr_i = A_STAT; bus_wdata_i = 32'hFEFE;
    @(negedge clk_i);
    force_rv = 1'b0; bus_we_i = 1'b0;
    bus_read(12'(4 * 100), r); chk("R9 word discarded", r, 32'h1111_2222);
    bus_read(A_STAT, r); chk("R9 idle after abort", {31'b0, r[0]}, 32'h1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule